// File: doc/BRIEF.md
# Keyboard-link command transmitter

This block sends one command byte from a host to a keyboard over a two-wire open-drain link. The link has a clock line and a data line, and the keyboard drives the clock. A byte enters through a valid/ready port. The block then pulls the clock low to inhibit the link for a programmable time. It pulls data low as a request-to-send, releases the clock, and shifts the frame out as the keyboard clocks it. It then releases data and looks for the keyboard's acknowledge. Each transfer ends with a one-cycle result pulse that carries a code: delivered, not acknowledged, or timed out.

The line outputs are active-high pull-down enables, one for each wire. Their line levels come back in through a synchronizer. While a transfer runs, a hold signal keeps the neighbouring receive path from treating the keyboard's clocking as an incoming frame. The command port has no buffering. `cmd_ready` is high only while the block is idle, and a byte is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. A source that holds `cmd_valid` while `cmd_ready` is low is simply stalled. The result pulse has no ready input and cannot be back-pressured.

Top module: `ps2_cmd_tx`

## Requirements
- R1: `cmd_ready` is high exactly when no transfer is in progress. A byte is accepted when `cmd_valid` and `cmd_ready` are both high, and the clock pull-down rises in the next cycle. `cmd_valid` pulses while `cmd_ready` is low start nothing.
- R2: After acceptance, the clock pull-down stays asserted for at least `INHIBIT_CYC` cycles before the data pull-down is asserted.
- R3: The data pull-down is asserted while the clock pull-down is still asserted. The clock is then released with data still pulled, and that low data level is the start bit.
- R4: On the falling clock edges 1 to 8 seen on the line, the block presents data bits 0 to 7 (LSB first). On edge 9 it presents the odd-parity bit, which makes the count of ones over data plus parity odd. A data value of 0 is driven as pull-down asserted.
- R5: On the 10th falling edge the block releases data for the stop position, and it keeps data released until the result.
- R6: The data line level is sampled at the 11th falling edge. Low gives result code 0 (delivered) and high gives code 1 (no acknowledge).
- R7: If no falling clock edge arrives within `RTS_TIMEOUT_CYC` cycles after the clock is released, the result is code 2 (timeout).
- R8: If the 11th falling edge has not arrived within `XFER_TIMEOUT_CYC` cycles after the first one, the result is code 2. Both pull-downs are then released.
- R9: `rx_hold` is high from the cycle after acceptance until the result pulse, and low otherwise.
- R10: `res_valid` is a single-cycle pulse with `res_code` valid alongside it. `cmd_ready` is high in the same cycle.
- R11: If the 11th falling edge and the expiry of the transfer timer fall in the same cycle, the edge wins and the acknowledge decides the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Block idle, byte will be taken |
| cmd_byte | input | 8 | Command byte |
| ps2_clk_in | input | 1 | Level of the shared clock line |
| ps2_dat_in | input | 1 | Level of the shared data line |
| ps2_clk_pull | output | 1 | Pull the clock line low |
| ps2_dat_pull | output | 1 | Pull the data line low |
| rx_hold | output | 1 | Hold off the receive path |
| res_valid | output | 1 | Transfer finished (one-cycle pulse) |
| res_code | output | 2 | 0 delivered, 1 no acknowledge, 2 timeout |

## Verification
The acknowledge decision at the 11th falling edge and the expiry of the transfer watchdog can land in the same cycle. The bench provokes this with a keyboard model whose bit period puts the 11th edge exactly `XFER_TIMEOUT_CYC`+1 cycles after the first. At that period the transfer must still report delivered. With the period stretched by one cycle, the same stimulus must report a timeout.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INHIBIT,
    ST_REQ,
    ST_WAIT,
    ST_SEND
  } tx_state_t;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_NOACK   = 2'd1,
    RES_TIMEOUT = 2'd2
  } tx_res_t;

  // falling edge at which the acknowledge is sampled
  localparam int ACK_EDGE = 11;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= line_in;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign level = chain[STAGES-1];
endmodule

// File: rtl/ps2tx_timer.sv
module ps2tx_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (en && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = en && !load && (cnt == '0);
endmodule

// File: rtl/ps2tx_shift.sv
module ps2tx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          adv,
  output logic          line_bit
);
  localparam int SW = DW + 2;
  logic [SW-1:0] sr;
  logic          cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '1;
      cur <= 1'b1;
    end else if (load) begin
      sr  <= {1'b1, ~^din, din};   // stop(release), odd parity, data
      cur <= 1'b0;                 // start bit
    end else if (adv) begin
      cur <= sr[0];
      sr  <= {1'b1, sr[SW-1:1]};
    end
  end

  assign line_bit = cur;
endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx
  import ps2tx_pkg::*;
#(
  parameter int INHIBIT_CYC      = 3000,
  parameter int RTS_TIMEOUT_CYC  = 500000,
  parameter int XFER_TIMEOUT_CYC = 100000,
  parameter int SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_byte,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  output logic       ps2_clk_pull,
  output logic       ps2_dat_pull,
  output logic       rx_hold,
  output logic       res_valid,
  output logic [1:0] res_code
);
  localparam int MAXT = max3(INHIBIT_CYC, RTS_TIMEOUT_CYC, XFER_TIMEOUT_CYC);
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] T_INH  = TW'(INHIBIT_CYC);
  localparam logic [TW-1:0] T_RTS  = TW'(RTS_TIMEOUT_CYC);
  localparam logic [TW-1:0] T_XFER = TW'(XFER_TIMEOUT_CYC);
  localparam logic [3:0]    LAST_EDGE = 4'(ACK_EDGE - 1);

  tx_state_t state, nxt_state;
  logic [3:0] fall_cnt, fall_cnt_nxt;
  logic clk_lvl, dat_lvl, clk_prev, clk_fall;
  logic tm_load, tm_en, tm_done;
  logic [TW-1:0] tm_val;
  logic sh_load, sh_adv, sh_bit;
  logic fin;
  tx_res_t fin_code;

  // line synchronizers
  ps2tx_sync #(.STAGES(SYNC_STAGES)) i_sync_clk (
    .clk(clk), .rst_n(rst_n), .line_in(ps2_clk_in), .level(clk_lvl));
  ps2tx_sync #(.STAGES(SYNC_STAGES)) i_sync_dat (
    .clk(clk), .rst_n(rst_n), .line_in(ps2_dat_in), .level(dat_lvl));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) clk_prev <= 1'b1;
    else        clk_prev <= clk_lvl;

  assign clk_fall = clk_prev && !clk_lvl;

  // one countdown for inhibit, request window and whole-frame watchdog
  ps2tx_timer #(.W(TW)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val),
    .en(tm_en), .expired(tm_done));

  ps2tx_shift #(.DW(8)) i_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .din(cmd_byte),
    .adv(sh_adv), .line_bit(sh_bit));

  assign tm_en = (state == ST_INHIBIT) || (state == ST_WAIT) || (state == ST_SEND);

  always_comb begin
    nxt_state    = state;
    fall_cnt_nxt = fall_cnt;
    tm_load      = 1'b0;
    tm_val       = T_INH;
    sh_load      = 1'b0;
    sh_adv       = 1'b0;
    fin          = 1'b0;
    fin_code     = RES_OK;
    unique case (state)
      ST_IDLE: begin
        if (cmd_valid) begin
          nxt_state = ST_INHIBIT;
          tm_load   = 1'b1;
          tm_val    = T_INH;
          sh_load   = 1'b1;
        end
      end
      ST_INHIBIT: begin
        if (tm_done) nxt_state = ST_REQ;
      end
      ST_REQ: begin
        nxt_state = ST_WAIT;
        tm_load   = 1'b1;
        tm_val    = T_RTS;
      end
      ST_WAIT: begin
        if (clk_fall) begin
          nxt_state    = ST_SEND;
          tm_load      = 1'b1;
          tm_val       = T_XFER;
          sh_adv       = 1'b1;
          fall_cnt_nxt = 4'd1;
        end else if (tm_done) begin
          nxt_state = ST_IDLE;
          fin       = 1'b1;
          fin_code  = RES_TIMEOUT;
        end
      end
      ST_SEND: begin
        // a falling edge takes priority over watchdog expiry in the same cycle
        if (clk_fall) begin
          if (fall_cnt == LAST_EDGE) begin
            nxt_state = ST_IDLE;
            fin       = 1'b1;
            fin_code  = dat_lvl ? RES_NOACK : RES_OK;
          end else begin
            sh_adv       = 1'b1;
            fall_cnt_nxt = fall_cnt + 4'd1;
          end
        end else if (tm_done) begin
          nxt_state = ST_IDLE;
          fin       = 1'b1;
          fin_code  = RES_TIMEOUT;
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fall_cnt  <= '0;
      res_valid <= 1'b0;
      res_code  <= RES_OK;
    end else begin
      state     <= nxt_state;
      fall_cnt  <= fall_cnt_nxt;
      res_valid <= fin;
      if (fin) res_code <= fin_code;
    end
  end

  assign cmd_ready    = (state == ST_IDLE);
  assign rx_hold      = (state != ST_IDLE);
  assign ps2_clk_pull = (state == ST_INHIBIT) || (state == ST_REQ);
  assign ps2_dat_pull = ((state == ST_REQ) || (state == ST_WAIT) || (state == ST_SEND)) && !sh_bit;

  // ---------------- assertions ----------------
  logic [TW:0] inh_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              inh_len <= '0;
    else if (!ps2_clk_pull)  inh_len <= '0;
    else if (inh_len != '1)  inh_len <= inh_len + 1'b1;

  a_r2_inhibit_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ps2_dat_pull) && ps2_clk_pull) |-> (int'(inh_len) >= INHIBIT_CYC));

  a_r3_data_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_pull) |-> ps2_dat_pull);

  a_r1_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!rx_hold && !ps2_clk_pull && !ps2_dat_pull));

  a_r5_released_for_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && fall_cnt == LAST_EDGE) |-> !ps2_dat_pull);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r9_hold_before_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(rx_hold));

  a_r4_fall_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fall |=> !clk_fall);
endmodule

// File: tb/test_ps2_cmd_tx.sv
module test_ps2_cmd_tx;
  localparam int CLK_PERIOD = 10;
  localparam int INH  = 40;
  localparam int RTS  = 400;
  localparam int XFER = 199;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       cmd_ready, ps2_clk_pull, ps2_dat_pull, rx_hold, res_valid;
  logic [1:0] res_code;
  logic       dev_clk = 1'b0, dev_dat = 1'b0;
  logic       line_clk, line_dat;

  assign line_clk = ~(ps2_clk_pull | dev_clk);
  assign line_dat = ~(ps2_dat_pull | dev_dat);

  ps2_cmd_tx #(.INHIBIT_CYC(INH), .RTS_TIMEOUT_CYC(RTS), .XFER_TIMEOUT_CYC(XFER),
               .SYNC_STAGES(2)) i_ps2_cmd_tx (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .ps2_clk_in(line_clk), .ps2_dat_in(line_dat),
    .ps2_clk_pull(ps2_clk_pull), .ps2_dat_pull(ps2_dat_pull), .rx_hold(rx_hold),
    .res_valid(res_valid), .res_code(res_code));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // line monitor
  int clk_run = 0, inh_at_req = 0;
  bit rel_ok = 0, saw_rel = 0, prev_d = 0, prev_c = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ps2_dat_pull && !prev_d && ps2_clk_pull) inh_at_req = clk_run;
      if (prev_c && !ps2_clk_pull) begin
        saw_rel = 1;
        rel_ok  = prev_d && ps2_dat_pull;
      end
      clk_run = ps2_clk_pull ? clk_run + 1 : 0;
      prev_d  = ps2_dat_pull;
      prev_c  = ps2_clk_pull;
    end
  end

  // keyboard model: h high cycles, sample, 1 cycle, l low cycles per bit
  task automatic dev_run(input int h, input int l, input int n, input bit ack,
                         output logic [10:0] seen);
    seen = '1;
    while (!(ps2_clk_pull == 1'b0 && ps2_dat_pull == 1'b1)) @(negedge clk);
    repeat (4) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      repeat (h) @(negedge clk);
      if (k < 11) seen[k] = line_dat;
      if (k == 10 && ack) dev_dat = 1'b1;
      @(negedge clk);
      dev_clk = 1'b1;
      repeat (l) @(negedge clk);
      dev_clk = 1'b0;
    end
    repeat (2) @(negedge clk);
    dev_dat = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    cmd_byte  = b;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(ps2_clk_pull == 1'b1 && cmd_ready == 1'b0, "R1 accept", ps2_clk_pull, 1);
    chk(rx_hold == 1'b1, "R9 hold raised", rx_hold, 1);
  endtask

  task automatic wait_result(input int limit, output logic [1:0] code, output int cyc);
    cyc  = 0;
    code = 2'b11;
    while (cyc < limit && !res_valid) begin
      @(negedge clk);
      cyc++;
    end
    chk(res_valid == 1'b1, "R10 result seen", res_valid, 1);
    code = res_code;
    chk(cmd_ready == 1'b1 && rx_hold == 1'b0, "R10 ready with result", cmd_ready, 1);
    @(negedge clk);
    chk(res_valid == 1'b0, "R10 single pulse", res_valid, 0);
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
    chk(!ps2_clk_pull && !ps2_dat_pull, "R1 reset lines", {ps2_clk_pull, ps2_dat_pull}, 0);
    chk(!rx_hold && !res_valid, "R9 reset hold", {rx_hold, res_valid}, 0);
  endtask

  task automatic t_normal(input logic [7:0] b);
    logic [10:0] seen;
    logic [1:0]  code;
    int          cyc;
    saw_rel = 0;
    fork
      dev_run(7, 8, 11, 1'b1, seen);
      begin send_cmd(b); wait_result(1000, code, cyc); end
    join
    chk(inh_at_req >= INH, "R2 inhibit length", inh_at_req, INH);
    chk(saw_rel && rel_ok, "R3 data low before release", rel_ok, 1);
    chk(seen[0] == 1'b0, "R3 start bit", seen[0], 0);
    chk(seen[8:1] == b, "R4 data bits", seen[8:1], b);
    chk(seen[9] == ~^b, "R4 odd parity", seen[9], ~^b);
    chk(seen[10] == 1'b1, "R5 stop released", seen[10], 1);
    chk(code == 2'd0, "R6 acknowledged", code, 0);
  endtask

  task automatic t_noack();
    logic [10:0] seen;
    logic [1:0]  code;
    int          cyc;
    fork
      dev_run(7, 8, 11, 1'b0, seen);
      begin send_cmd(8'hF4); wait_result(1000, code, cyc); end
    join
    chk(code == 2'd1, "R6 missing acknowledge", code, 1);
  endtask

  task automatic t_no_clock();
    logic [1:0] code;
    int         cyc;
    send_cmd(8'hFF);
    wait_result(2000, code, cyc);
    chk(code == 2'd2, "R7 request timeout", code, 2);
    chk(cyc >= RTS + INH, "R7 waited window", cyc, RTS + INH);
    chk(!ps2_clk_pull && !ps2_dat_pull, "R7 lines released", ps2_dat_pull, 0);
  endtask

  task automatic t_stall();
    logic [10:0] seen;
    logic [1:0]  code;
    int          cyc;
    fork
      dev_run(7, 8, 4, 1'b0, seen);
      begin send_cmd(8'hAA); wait_result(1000, code, cyc); end
    join
    chk(code == 2'd2, "R8 frame watchdog", code, 2);
    chk(!ps2_clk_pull && !ps2_dat_pull && !rx_hold, "R8 lines released", ps2_dat_pull, 0);
  endtask

  task automatic t_collide(input int h, input int l, input logic [1:0] expc, input string tag);
    logic [10:0] seen;
    logic [1:0]  code;
    int          cyc;
    fork
      dev_run(h, l, 11, 1'b1, seen);
      begin send_cmd(8'h3C); wait_result(1000, code, cyc); end
    join
    chk(code == expc, tag, code, expc);
  endtask

  task automatic t_busy_ignore();
    logic [10:0] seen;
    logic [1:0]  code;
    int          cyc;
    bit          started;
    fork
      dev_run(7, 8, 11, 1'b1, seen);
      begin send_cmd(8'h12); wait_result(1000, code, cyc); end
      begin
        repeat (100) @(negedge clk);
        chk(cmd_ready == 1'b0, "R1 not ready while busy", cmd_ready, 0);
        cmd_byte  = 8'h55;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    started = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ps2_clk_pull || rx_hold) started = 1;
    end
    chk(!started, "R1 busy strobe ignored", started, 0);
    chk(seen[8:1] == 8'h12, "R1 byte kept", seen[8:1], 8'h12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_normal(8'hED);
    t_normal(8'h00);
    t_normal(8'hFF);
    t_noack();
    t_no_clock();
    t_stall();
    // 11th edge exactly when the watchdog expires: edge wins (R11)
    t_collide(9, 10, 2'd0, "R11 edge wins at expiry");
    // one cycle slower: watchdog first
    t_collide(10, 10, 2'd2, "R8 one cycle late");
    t_busy_ignore();
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule